// File: doc/BRIEF.md
# Video-mode line packet sequencer

This block produces the ordered list of packet descriptors for one display line on a serial display link running in video mode. Software fills two small tables through a plain register write port. The first table holds a program of two 32-bit words for each line kind. The second table holds eight 16-bit payload lengths. When a line request arrives, the line-type input selects one program. The block then issues one descriptor for each enabled packet slot of that program, in slot order. Each descriptor carries the packet data type and a word count taken from the length table.

A line ends with a one-cycle done pulse. A low-power flag goes out with that pulse and tells the link whether to drop to low power before the next line. Typical programs are the following. Vsync-start, vsync-end and vertical-blanking lines each issue sync start, blanking and sync end, and then request low power. An active line issues hsync start, blanking, hsync end, back-porch blanking, pixel stream and front-porch blanking, with no low-power request.

Software derives the lengths from the sync width, back porch and front porch. Each value is scaled to bytes (times 3/1 for 24-bit or loosely packed 18-bit pixels, 2/1 for 16-bit, 9/4 for tightly packed 18-bit). Fixed overheads of 10, 14 and 8 bytes are then taken off the three values respectively. The block does not generate error-correction codes or checksums. It does not serialize lanes and does not move pixel data.

Top module: `line_pkt_seq`

## Requirements
- R1: After reset, line_ready is 1, desc_valid and line_done are 0, and every program word and length entry reads as zero. A request issued before any write therefore yields no descriptor, a done pulse, and line_lp 0.
- R2: Write address 2p loads the first (LO) program word of line type p, and address 2p+1 loads its second (HI) word, for p in 0..5. Address 12+k loads length entries 2k (bits 15:0) and 2k+1 (bits 31:16), for k in 0..3.
- R3: In a program word, slot s (s = 0,1,2) has its length index in bits [10s+2:10s], its 6-bit data type in bits [10s+8:10s+3], and its enable in bit 10s+9. The descriptor's desc_dtype equals that data type.
- R4: Slots are issued in the order LO slot 0, 1, 2, then HI slot 0, 1, 2. Disabled slots are skipped. With desc_ready held at 1, enabled slots leave on consecutive cycles with no gap.
- R5: desc_wcount equals the length entry that the slot's 3-bit index selects.
- R6: While desc_valid is 1 and desc_ready is 0, desc_valid, desc_dtype and desc_wcount hold their values into the next cycle.
- R7: A request is accepted only in a cycle where line_ready is 1. line_ready is 0 from the cycle after acceptance until the line ends. Requests made while busy are ignored.
- R8: line_done is a one-cycle pulse. It comes in the cycle after the last descriptor handshake, or in the cycle after acceptance when no slot is enabled. line_ready returns to 1 in the cycle after the pulse.
- R9: line_lp equals bit 30 of the LO word OR bit 30 of the HI word of the running program, and it is valid during the done pulse.
- R10: Table writes made in the acceptance cycle or later do not change the running line. They apply from the next accepted line.
- R11: A line_type of 6 or 7 is accepted, issues no descriptor, and ends with line_lp 0.
- R12: In the cycle after acceptance, either desc_valid (first enabled slot) or line_done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 4 | Table word address (R2) |
| cfg_wdata | input | 32 | Table write data |
| line_req | input | 1 | Request to run one line |
| line_type | input | 3 | Program selected by the request |
| line_ready | output | 1 | Sequencer idle, request can be taken |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_dtype | output | 6 | Packet data type |
| desc_wcount | output | 16 | Packet word count |
| line_done | output | 1 | End-of-line pulse |
| line_lp | output | 1 | Low-power request, valid with line_done |

## Verification
Programs shaped like real sync, blanking and active lines show the full six-slot order with consecutive issue. A sparse program is also run: it has disabled slots that still hold non-zero fields, a length index that selects an odd entry, and a low-power bit only in the HI word. This separates correct field positions, skipping and the OR of the two low-power bits from near-miss decodes. A pseudo-random desc_ready pattern exposes descriptors that move or vanish under backpressure. Back-to-back requests, table writes made in the acceptance cycle and during a line, and out-of-range line types separate snapshot-at-accept behaviour from reading the live tables.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int WORD_W         = 32;
  localparam int SLOTS_PER_WORD = 3;
  localparam int SLOT_STRIDE    = 10;
  localparam int IDX_W          = 3;
  localparam int DT_W           = 6;
  localparam int LEN_W          = 16;
  localparam int EN_OFS         = IDX_W + DT_W;
  localparam int LP_BIT         = 30;
  localparam int LEN_ENTRIES    = 1 << IDX_W;
  localparam int LEN_REGS       = LEN_ENTRIES / 2;
  localparam int LINE_SLOTS     = 2 * SLOTS_PER_WORD;
  localparam int SLOT_IW        = $clog2(LINE_SLOTS);

  typedef struct packed {
    logic [DT_W-1:0]  dtype;
    logic [LEN_W-1:0] wcount;
  } pkt_desc_t;
endpackage

// File: rtl/lps_regfile.sv
module lps_regfile
  import lps_pkg::*;
#(
  parameter int NUM_PAIRS = 6,
  parameter int ADDR_W    = 4,
  parameter int PSEL_W    = 3
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [WORD_W-1:0]                wr_data,
  input  logic [PSEL_W-1:0]                rd_pair,
  output logic [WORD_W-1:0]                rd_lo,
  output logic [WORD_W-1:0]                rd_hi,
  output logic [LEN_REGS-1:0][WORD_W-1:0]  len_tbl
);
  localparam int PROG_WORDS = 2 * NUM_PAIRS;

  logic [PROG_WORDS-1:0][WORD_W-1:0]  prog_q;
  logic [LEN_REGS-1:0][WORD_W-1:0]    len_q;
  logic [PROG_WORDS-1:0]              prog_we;
  logic [LEN_REGS-1:0]                len_we;

  for (genvar w = 0; w < PROG_WORDS; w++) begin : g_prog_we
    assign prog_we[w] = wr_en && (wr_addr == ADDR_W'(w));
  end
  for (genvar k = 0; k < LEN_REGS; k++) begin : g_len_we
    assign len_we[k] = wr_en && (wr_addr == ADDR_W'(PROG_WORDS + k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      len_q  <= '0;
    end else begin
      for (int w = 0; w < PROG_WORDS; w++)
        if (prog_we[w]) prog_q[w] <= wr_data;
      for (int k = 0; k < LEN_REGS; k++)
        if (len_we[k]) len_q[k] <= wr_data;
    end
  end

  always_comb begin
    int unsigned p;
    p     = int'(rd_pair);
    rd_lo = '0;
    rd_hi = '0;
    if (p < NUM_PAIRS) begin
      rd_lo = prog_q[2*p];
      rd_hi = prog_q[2*p+1];
    end
  end

  assign len_tbl = len_q;
endmodule

// File: rtl/lps_slot_pick.sv
module lps_slot_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  mask,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    grant = '0;
    idx   = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (mask[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IW'(i);
      end
    end
  end

  assign any = |mask;
endmodule

// File: rtl/lps_seq.sv
module lps_seq
  import lps_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             line_req,
  input  logic [WORD_W-1:0]                prog_lo,
  input  logic [WORD_W-1:0]                prog_hi,
  input  logic [LEN_REGS-1:0][WORD_W-1:0]  len_tbl,
  output logic                             line_ready,
  output logic                             desc_valid,
  input  logic                             desc_ready,
  output logic [DT_W-1:0]                  desc_dtype,
  output logic [LEN_W-1:0]                 desc_wcount,
  output logic                             line_done,
  output logic                             line_lp
);
  logic                   run_q, run_d;
  logic                   lp_q, lp_d;
  logic [LINE_SLOTS-1:0]  pend_q, pend_d;
  pkt_desc_t              slot_q [LINE_SLOTS];
  pkt_desc_t              slot_d [LINE_SLOTS];
  logic [LINE_SLOTS-1:0]  en_new;
  logic [LINE_SLOTS-1:0]  grant;
  logic [SLOT_IW-1:0]     cur;
  logic                   any_pend;
  logic                   accept;

  lps_slot_pick #(.N(LINE_SLOTS), .IW(SLOT_IW)) u_pick (
    .mask  (pend_q),
    .grant (grant),
    .idx   (cur),
    .any   (any_pend)
  );

  assign accept = !run_q && line_req;

  // Resolve every slot of the selected program at acceptance time.
  always_comb begin
    for (int s = 0; s < LINE_SLOTS; s++) begin
      logic [WORD_W-1:0] w;
      logic [IDX_W-1:0]  ix;
      int                b;
      w  = (s < SLOTS_PER_WORD) ? prog_lo : prog_hi;
      b  = (s % SLOTS_PER_WORD) * SLOT_STRIDE;
      ix = w[b +: IDX_W];
      en_new[s]        = w[b + EN_OFS];
      slot_d[s].dtype  = w[b + IDX_W +: DT_W];
      slot_d[s].wcount = ix[0] ? len_tbl[ix[IDX_W-1:1]][2*LEN_W-1:LEN_W]
                               : len_tbl[ix[IDX_W-1:1]][LEN_W-1:0];
    end
  end

  // Next state.
  always_comb begin
    run_d  = run_q;
    lp_d   = lp_q;
    pend_d = pend_q;
    if (accept) begin
      run_d  = 1'b1;
      pend_d = en_new;
      lp_d   = prog_lo[LP_BIT] | prog_hi[LP_BIT];
    end else if (run_q) begin
      if (!any_pend)
        run_d = 1'b0;
      else if (desc_ready)
        pend_d = pend_q & ~grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      lp_q   <= 1'b0;
      pend_q <= '0;
    end else begin
      run_q  <= run_d;
      lp_q   <= lp_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < LINE_SLOTS; s++) slot_q[s] <= '0;
    end else if (accept) begin
      for (int s = 0; s < LINE_SLOTS; s++) slot_q[s] <= slot_d[s];
    end
  end

  assign line_ready  = !run_q;
  assign desc_valid  = run_q && any_pend;
  assign desc_dtype  = slot_q[cur].dtype;
  assign desc_wcount = slot_q[cur].wcount;
  assign line_done   = run_q && !any_pend;
  assign line_lp     = line_done && lp_q;

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_dtype) && $stable(desc_wcount));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done && line_ready);
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && line_ready |=> !line_ready);
  // R12
  first_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && line_ready |=> desc_valid || line_done);
  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~pend_q) == '0));
endmodule

// File: rtl/line_pkt_seq.sv
module line_pkt_seq
  import lps_pkg::*;
#(
  parameter  int NUM_PAIRS = 6,
  localparam int PSEL_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int ADDR_W    = $clog2(2 * NUM_PAIRS + LEN_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              line_req,
  input  logic [PSEL_W-1:0] line_type,
  output logic              line_ready,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [DT_W-1:0]   desc_dtype,
  output logic [LEN_W-1:0]  desc_wcount,
  output logic              line_done,
  output logic              line_lp
);
  logic [1:0]                        rst_sync_q;
  logic                              srst_n;
  logic [WORD_W-1:0]                 prog_lo, prog_hi;
  logic [LEN_REGS-1:0][WORD_W-1:0]   len_tbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  lps_regfile #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W), .PSEL_W(PSEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .rd_pair (line_type),
    .rd_lo   (prog_lo),
    .rd_hi   (prog_hi),
    .len_tbl (len_tbl)
  );

  lps_seq u_seq (
    .clk         (clk),
    .rst_n       (srst_n),
    .line_req    (line_req),
    .prog_lo     (prog_lo),
    .prog_hi     (prog_hi),
    .len_tbl     (len_tbl),
    .line_ready  (line_ready),
    .desc_valid  (desc_valid),
    .desc_ready  (desc_ready),
    .desc_dtype  (desc_dtype),
    .desc_wcount (desc_wcount),
    .line_done   (line_done),
    .line_lp     (line_lp)
  );
endmodule

// File: tb/tb_line_pkt_seq.sv
`timescale 1ns/1ps
module tb_line_pkt_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        line_req = 1'b0;
  logic [2:0]  line_type = '0;
  logic        desc_ready = 1'b1;
  logic        line_ready, desc_valid, line_done, line_lp;
  logic [5:0]  desc_dtype;
  logic [15:0] desc_wcount;

  always #2.5 clk = ~clk;

  line_pkt_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .line_req(line_req), .line_type(line_type),
    .line_ready(line_ready), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_dtype(desc_dtype), .desc_wcount(desc_wcount),
    .line_done(line_done), .line_lp(line_lp)
  );

  int vectors = 0;
  int miscompares = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
               tag, act, act, exp, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_prog [12];
  bit [15:0] m_len  [8];
  bit [21:0] m_q [$];
  bit        m_run, m_lp, m_just_acc;
  bit        armed = 1'b0;
  int        acc_cnt = 0, done_cnt = 0, hs_cnt = 0;
  bit        prev_hold;
  bit [5:0]  prev_dt;
  bit [15:0] prev_wc;

  always @(posedge clk) begin
    prev_hold = desc_valid && !desc_ready;
    prev_dt   = desc_dtype;
    prev_wc   = desc_wcount;
    if (line_req && line_ready) acc_cnt++;
    if (line_done) done_cnt++;
    if (desc_valid && desc_ready) hs_cnt++;
    if (!rst_n) begin
      foreach (m_prog[i]) m_prog[i] = '0;
      foreach (m_len[i]) m_len[i] = '0;
      m_q.delete();
      m_run = 0; m_lp = 0; m_just_acc = 0;
    end else begin
      m_just_acc = 0;
      if (m_run) begin
        if (m_q.size() == 0) m_run = 0;
        else if (desc_ready) void'(m_q.pop_front());
      end else if (line_req) begin
        m_q.delete();
        m_lp = 0;
        if (line_type < 6) begin
          bit [31:0] lo, hi;
          lo = m_prog[2*line_type];
          hi = m_prog[2*line_type+1];
          for (int s = 0; s < 6; s++) begin
            bit [31:0] w;
            int b;
            w = (s < 3) ? lo : hi;
            b = (s % 3) * 10;
            if (w[b+9]) m_q.push_back({w[b+3 +: 6], m_len[w[b +: 3]]});
          end
          m_lp = lo[30] | hi[30];
        end
        m_run = 1;
        m_just_acc = 1;
      end
      if (cfg_we) begin
        if (cfg_addr < 12) m_prog[cfg_addr] = cfg_wdata;
        else begin
          m_len[2*(cfg_addr-12)]   = cfg_wdata[15:0];
          m_len[2*(cfg_addr-12)+1] = cfg_wdata[31:16];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      bit ev, ed;
      ev = m_run && (m_q.size() != 0);
      ed = m_run && (m_q.size() == 0);
      chk(line_ready == !m_run, "R7 line_ready", line_ready, !m_run);
      chk(desc_valid == ev, "R4 desc_valid", desc_valid, ev);
      if (ev) begin
        chk(desc_dtype == m_q[0][21:16], "R3 desc_dtype", desc_dtype, m_q[0][21:16]);
        chk(desc_wcount == m_q[0][15:0], "R5 desc_wcount", desc_wcount, m_q[0][15:0]);
      end
      chk(line_done == ed, "R8 line_done", line_done, ed);
      if (ed) chk(line_lp == m_lp, "R9 line_lp", line_lp, m_lp);
      if (prev_hold) begin
        chk(desc_valid && desc_dtype == prev_dt && desc_wcount == prev_wc,
            "R6 hold under backpressure", desc_wcount, prev_wc);
      end
      if (m_just_acc) chk(desc_valid || line_done, "R12 first cycle after accept",
                          desc_valid || line_done, 1);
    end
  end

  // ---------------- backpressure source ----------------
  bit       bp_on = 1'b0;
  bit [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    desc_ready <= bp_on ? lfsr[0] : 1'b1;
  end

  // ---------------- stimulus helpers ----------------
  function automatic bit [31:0] slot(input int s, input bit [5:0] dt, input bit [2:0] ix);
    bit [31:0] v;
    v = '0;
    v[10*s +: 3]   = ix;
    v[10*s+3 +: 6] = dt;
    v[10*s+9]      = 1'b1;
    return v;
  endfunction

  function automatic bit [15:0] scaled(input int px, input int mul, input int dv, input int ovh);
    return 16'((px * mul) / dv - ovh);
  endfunction

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load_lengths(input int mul, input int dv);
    wr(4'd12, {scaled(32, mul, dv, 10), 16'd0});
    wr(4'd13, {scaled(64, mul, dv, 0), scaled(48, mul, dv, 14)});
    wr(4'd14, {16'd0, scaled(16, mul, dv, 8)});
    wr(4'd15, {16'h0f0f, 16'h0f0f});
  endtask

  task automatic run_line(input string tag, input bit [2:0] t, input int exp_cnt);
    int a0, d0, h0;
    @(negedge clk);
    while (!line_ready) @(negedge clk);
    a0 = acc_cnt; d0 = done_cnt; h0 = hs_cnt;
    line_req = 1; line_type = t;
    wait (acc_cnt != a0);
    @(negedge clk);
    line_req = 0;
    wait (done_cnt != d0);
    @(negedge clk);
    chk(hs_cnt - h0 == exp_cnt, tag, hs_cnt - h0, exp_cnt);
  endtask

  localparam bit [5:0] DT_VSS = 6'h01, DT_VSE = 6'h11, DT_HSS = 6'h21,
                       DT_HSE = 6'h31, DT_BLK = 6'h19, DT_PIX = 6'h3E;

  // ---------------- main sequence ----------------
  initial begin
    bit [31:0] sync_tail, act_lo, act_hi;
    int a0, d0, h0;
    repeat (3) @(negedge clk);
    chk(line_ready == 1 && desc_valid == 0 && line_done == 0, "R1 reset outputs",
        {line_ready, desc_valid, line_done}, 3'b100);
    rst_n = 1;
    repeat (4) @(negedge clk);
    armed = 1;

    run_line("R1 empty tables give no descriptors", 3'd3, 0);

    sync_tail = slot(1, DT_BLK, 3'd1) | slot(2, DT_HSE, 3'd0) | (32'h1 << 30);
    act_lo    = slot(0, DT_HSS, 3'd0) | slot(1, DT_BLK, 3'd1) | slot(2, DT_HSE, 3'd0);
    act_hi    = slot(0, DT_BLK, 3'd2) | slot(1, DT_PIX, 3'd3) | slot(2, DT_BLK, 3'd4);
    wr(4'd0, slot(0, DT_VSS, 3'd0) | sync_tail);
    wr(4'd2, slot(0, DT_VSE, 3'd0) | sync_tail);
    wr(4'd4, slot(0, DT_HSS, 3'd0) | sync_tail);
    wr(4'd6, act_lo);
    wr(4'd7, act_hi);
    // sparse program: disabled fields left non-zero, low-power bit only in HI
    wr(4'd8, 32'h0000_01FF | slot(2, DT_BLK, 3'd4));
    wr(4'd9, 32'h0000_01FF | slot(1, 6'h2A, 3'd7) | (32'h1 << 30));
    wr(4'd10, act_lo);
    wr(4'd11, act_hi);
    load_lengths(3, 1);

    run_line("R2 vsync-start program", 3'd0, 3);
    run_line("R2 vsync-end program", 3'd1, 3);
    run_line("R2 blanking program", 3'd2, 3);
    run_line("R4 active line six slots", 3'd3, 6);
    run_line("R3 sparse program skips disabled", 3'd4, 2);
    run_line("R11 line type 6", 3'd6, 0);
    run_line("R11 line type 7", 3'd7, 0);

    bp_on = 1;
    run_line("R6 active line under backpressure", 3'd5, 6);
    run_line("R6 sparse line under backpressure", 3'd4, 2);
    bp_on = 0;

    // R10: writes during a running line
    @(negedge clk);
    a0 = acc_cnt; d0 = done_cnt; h0 = hs_cnt;
    line_req = 1; line_type = 3'd3;
    wait (acc_cnt != a0);
    @(negedge clk);
    line_req = 0;
    cfg_we = 1; cfg_addr = 4'd7; cfg_wdata = slot(1, DT_PIX, 3'd3);
    @(negedge clk);
    cfg_addr = 4'd13; cfg_wdata = {16'd777, 16'd555};
    @(negedge clk);
    cfg_we = 0;
    wait (done_cnt != d0);
    @(negedge clk);
    chk(hs_cnt - h0 == 6, "R10 running line keeps old program", hs_cnt - h0, 6);
    run_line("R10 next line uses new program", 3'd3, 4);

    // R10: write in the acceptance cycle
    @(negedge clk);
    a0 = acc_cnt; d0 = done_cnt; h0 = hs_cnt;
    line_req = 1; line_type = 3'd3;
    cfg_we = 1; cfg_addr = 4'd7; cfg_wdata = act_hi;
    wait (acc_cnt != a0);
    @(negedge clk);
    line_req = 0; cfg_we = 0;
    wait (done_cnt != d0);
    @(negedge clk);
    chk(hs_cnt - h0 == 4, "R10 write in accept cycle deferred", hs_cnt - h0, 4);

    load_lengths(9, 4);
    run_line("R5 tightly packed 18-bit lengths", 3'd5, 6);

    // R7/R8: request held high across lines, back to back
    @(negedge clk);
    a0 = acc_cnt; d0 = done_cnt; h0 = hs_cnt;
    line_req = 1; line_type = 3'd0;
    wait (acc_cnt == a0 + 1);
    @(negedge clk);
    line_type = 3'd3;
    wait (acc_cnt == a0 + 2);
    @(negedge clk);
    line_req = 0;
    wait (done_cnt == d0 + 2);
    @(negedge clk);
    chk(hs_cnt - h0 == 9, "R7 back-to-back lines", hs_cnt - h0, 9);
    chk(acc_cnt - a0 == 2, "R8 one accept per line", acc_cnt - a0, 2);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule